// File: doc/BRIEF.md
# SPI Mode-0 Master Frame Sequencer

This block is a synchronous serial master for clock polarity 0 and clock phase 0. It pulls one word at a time from a transmit FIFO through a non-empty flag and a pop strobe. It shifts the word out most significant bit first while shifting a word in from the slave. At the end of each frame it hands the received word to the next stage with a one-cycle valid pulse. Every output is a register in the system clock domain.

The serial clock period is `2*H` system cycles, where `H = max(cfg_half, 1)`. The word length is `N`, which is `cfg_bits` clamped to the range 4..16. Both values are captured when a word is loaded, so they change only at a frame boundary.

A frame runs through these states:
- **IDLE**: the block waits. When `enable && tx_nonempty`, it moves to LEAD and loads the word.
- **LEAD**: frame select is low and the data line is not yet driven. After H cycles it moves to LOW.
- **LOW**: the serial clock is low. After H cycles it moves to HIGH and samples `miso`.
- **HIGH**: the serial clock is high. After H cycles it moves back to LOW, shifting out the next bit, or to TAIL once N bits are in.
- **TAIL**: this state holds the one period after the last capture. It moves to GAP_A if another word is ready and loads that word. Otherwise it returns to IDLE.
- **GAP_A** then **GAP_B**: frame select is high and the data pad stays enabled. Each lasts H cycles, and GAP_B moves to LEAD.

Top module: `spi_m0_sequencer`

## Requirements
- R1: During and after reset, and whenever idle, the outputs rest at these levels: `sclk`=0, `frame_n`=1, `mosi`=0, `data_oe_n`=1, `tx_pop`=0, `rx_valid`=0.
- R2: `clk_oe_n` is 0 at all times, because the clock pad is always driven in master operation.
- R3: A frame starts only when the block is idle with `enable` and `tx_nonempty` high. `frame_n` and `data_oe_n` then fall in the same cycle, and `tx_pop` is high for exactly that one cycle, once per word.
- R4: `mosi` carries bit N-1 of the word H cycles after `frame_n` falls. The first rising edge of `sclk` comes 2H cycles after `frame_n` falls.
- R5: Each frame has exactly N rising edges of `sclk`, and these edges occur only while `frame_n` is low. N is `cfg_bits` limited to 4..16. The bits on `mosi` at those edges are `tx_word[N-1:0]`, most significant bit first.
- R6: `miso` is sampled on each rising edge of `sclk`, and `mosi` changes only away from a rising edge. `rx_word[N-1:0]` holds the sampled bits with the first one at bit N-1, and the upper bits of `rx_word` are 0.
- R7: `frame_n` rises 2H cycles after the last rising edge of `sclk`. `rx_valid` is a one-cycle pulse in the same cycle in which `frame_n` rises.
- R8: If `enable && tx_nonempty` hold when a frame ends, `frame_n` stays high for exactly 2H cycles and then falls for the next word. `data_oe_n` stays low through that gap.
- R9: `data_oe_n` rises only together with `frame_n`, at the end of the last frame of a transfer.
- R10: `cfg_bits` and `cfg_half` are captured when a word is loaded. Changing them during a frame alters neither that frame's bit count nor its timing.
- R11: While `enable` is low, no new frame starts and no pop is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows new frames to start |
| cfg_bits | input | 5 | Word length request, clamped to 4..16 |
| cfg_half | input | 8 | Half serial period in system cycles (0 treated as 1) |
| tx_nonempty | input | 1 | Transmit FIFO holds a word |
| tx_word | input | 16 | Word at the head of the transmit FIFO |
| tx_pop | output | 1 | One-cycle pop of the transmit FIFO |
| rx_valid | output | 1 | One-cycle strobe for `rx_word` |
| rx_word | output | 16 | Last received word, right aligned |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock, idle low |
| frame_n | output | 1 | Frame select, active low |
| mosi | output | 1 | Serial data to the slave |
| data_oe_n | output | 1 | Data pad output enable, active low |
| clk_oe_n | output | 1 | Clock pad output enable, active low |

## Verification
The assertions check the following on every cycle: the idle levels, the constant clock-pad enable, and that clock edges occur only inside a frame. They also check that `mosi` holds still at each rising edge, that `rx_valid` pulses together with the rise of `frame_n`, that the pad enable changes only with frame select, and that pops are single-cycle. Some properties depend on the word and on the configuration captured at load, so only the bench scenarios can show them. These are the exact 2H lead, tail and gap lengths, the bit count, and the received and transmitted word values. The bench scenarios also cover the clamping of out-of-range settings, a configuration change in mid-frame, and the hold-off while `enable` is low.

// File: rtl/spi_m0_pkg.sv
package spi_m0_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LOW,
        ST_HIGH,
        ST_TAIL,
        ST_GAP_A,
        ST_GAP_B
    } seq_state_e;
endpackage

// File: rtl/spi_m0_half_timer.sv
// Counts system cycles inside one half serial period; pulses tick on the last one.
module spi_m0_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == half - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/spi_m0_shifter.sv
// Transmit shift register (MSB aligned) and receive accumulator (LSB filled).
module spi_m0_shifter #(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LEN_W-1:0]  load_len,
    input  logic [DATA_W-1:0] load_word,
    input  logic              shift_en,
    input  logic              sample_en,
    input  logic              miso,
    output logic              out_msb,
    output logic              out_next,
    output logic [DATA_W-1:0] rx_acc
);
    logic [DATA_W-1:0] tx_sh;
    logic [LEN_W-1:0]  align;

    assign align    = LEN_W'(DATA_W) - load_len;
    assign out_msb  = tx_sh[DATA_W-1];
    assign out_next = tx_sh[DATA_W-2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh  <= '0;
            rx_acc <= '0;
        end else if (load) begin
            tx_sh  <= load_word << align;
            rx_acc <= '0;
        end else begin
            if (shift_en)
                tx_sh <= tx_sh << 1;
            if (sample_en)
                rx_acc <= {rx_acc[DATA_W-2:0], miso};
        end
    end
endmodule

// File: rtl/spi_m0_sequencer.sv
module spi_m0_sequencer
    import spi_m0_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int MIN_W  = 4,
    parameter int DIV_W  = 8,
    localparam int LEN_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [LEN_W-1:0]  cfg_bits,
    input  logic [DIV_W-1:0]  cfg_half,
    input  logic              tx_nonempty,
    input  logic [DATA_W-1:0] tx_word,
    output logic              tx_pop,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_word,
    input  logic              miso,
    output logic              sclk,
    output logic              frame_n,
    output logic              mosi,
    output logic              data_oe_n,
    output logic              clk_oe_n
);
    seq_state_e        state_q, state_d;
    logic [LEN_W-1:0]  bits_q, bit_cnt_q, len_eff;
    logic [DIV_W-1:0]  half_q, half_eff;
    logic              tick, start_ok, load, shift_en, sample_en;
    logic              sh_msb, sh_next;
    logic [DATA_W-1:0] rx_acc;
    logic              in_frame_d, in_gap_d;

    // Clamp configuration to the legal ranges.
    always_comb begin
        if (cfg_bits < LEN_W'(MIN_W))
            len_eff = LEN_W'(MIN_W);
        else if (cfg_bits > LEN_W'(DATA_W))
            len_eff = LEN_W'(DATA_W);
        else
            len_eff = cfg_bits;
        half_eff = (cfg_half == '0) ? DIV_W'(1) : cfg_half;
    end

    assign start_ok = enable && tx_nonempty;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_ok) state_d = ST_LEAD;
            ST_LEAD:  if (tick) state_d = ST_LOW;
            ST_LOW:   if (tick) state_d = ST_HIGH;
            ST_HIGH:  if (tick) state_d = (bit_cnt_q == bits_q) ? ST_TAIL : ST_LOW;
            ST_TAIL:  if (tick) state_d = start_ok ? ST_GAP_A : ST_IDLE;
            ST_GAP_A: if (tick) state_d = ST_GAP_B;
            ST_GAP_B: if (tick) state_d = ST_LEAD;
            default:  state_d = ST_IDLE;
        endcase
    end

    assign load      = ((state_q == ST_IDLE) && start_ok) ||
                       ((state_q == ST_TAIL) && tick && start_ok);
    assign sample_en = (state_q == ST_LOW) && tick;
    assign shift_en  = (state_q == ST_HIGH) && tick && (state_d == ST_LOW);
    assign in_frame_d = (state_d == ST_LEAD) || (state_d == ST_LOW) ||
                        (state_d == ST_HIGH) || (state_d == ST_TAIL);
    assign in_gap_d   = (state_d == ST_GAP_A) || (state_d == ST_GAP_B);

    spi_m0_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q != ST_IDLE),
        .half  (half_q),
        .tick  (tick)
    );

    spi_m0_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_len  (len_eff),
        .load_word (tx_word),
        .shift_en  (shift_en),
        .sample_en (sample_en),
        .miso      (miso),
        .out_msb   (sh_msb),
        .out_next  (sh_next),
        .rx_acc    (rx_acc)
    );

    // State register with the per-frame configuration and bit count.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            bits_q    <= LEN_W'(MIN_W);
            half_q    <= DIV_W'(1);
            bit_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (load) begin
                bits_q    <= len_eff;
                half_q    <= half_eff;
                bit_cnt_q <= '0;
            end else if (sample_en) begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
            end
        end
    end

    // Registered pin and strobe outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk      <= 1'b0;
            frame_n   <= 1'b1;
            mosi      <= 1'b0;
            data_oe_n <= 1'b1;
            clk_oe_n  <= 1'b0;
            tx_pop    <= 1'b0;
            rx_valid  <= 1'b0;
            rx_word   <= '0;
        end else begin
            clk_oe_n  <= 1'b0;
            tx_pop    <= load;
            rx_valid  <= 1'b0;
            sclk      <= (state_d == ST_HIGH);
            frame_n   <= !in_frame_d;
            data_oe_n <= (state_d == ST_IDLE);
            if ((state_q == ST_LEAD) && tick)
                mosi <= sh_msb;
            else if (shift_en)
                mosi <= sh_next;
            else if ((state_d == ST_IDLE) || in_gap_d)
                mosi <= 1'b0;
            if ((state_q == ST_TAIL) && tick) begin
                rx_valid <= 1'b1;
                rx_word  <= rx_acc;
            end
        end
    end
endmodule

// File: rtl/spi_m0_sequencer_chk.sv
module spi_m0_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic frame_n,
    input logic mosi,
    input logic data_oe_n,
    input logic clk_oe_n,
    input logic tx_pop,
    input logic rx_valid
);
    // R2
    clk_pad_low_chk: assert property (@(posedge clk) disable iff (!rst_n) !clk_oe_n);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_n |-> (frame_n && !sclk && !mosi));
    // R5
    clock_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !frame_n);
    // R6
    mosi_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(mosi));
    // R7
    valid_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $rose(frame_n));
    // R7
    rise_gives_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_n) |-> rx_valid);
    // R3
    single_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |=> !tx_pop);
    // R3
    oe_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_oe_n) |-> $fell(frame_n));
    // R9
    oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_oe_n) |-> $rose(frame_n));
endmodule

bind spi_m0_sequencer spi_m0_sequencer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk      (sclk),
    .frame_n   (frame_n),
    .mosi      (mosi),
    .data_oe_n (data_oe_n),
    .clk_oe_n  (clk_oe_n),
    .tx_pop    (tx_pop),
    .rx_valid  (rx_valid)
);

// File: tb/spi_m0_sequencer_test.sv
module spi_m0_sequencer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [4:0]  cfg_bits = 5'd8;
    logic [7:0]  cfg_half = 8'd1;
    logic        tx_nonempty, tx_pop, rx_valid, miso, sclk, frame_n, mosi, data_oe_n, clk_oe_n;
    logic [15:0] tx_word, rx_word;

    always #5 clk = ~clk;

    // Transmit FIFO model and slave word queue
    logic [15:0] q [16];
    logic [15:0] sl_q [16];
    int nq = 0, rd = 0, sidx = 0;
    assign tx_nonempty = (rd < nq);
    assign tx_word     = (rd < 16) ? q[rd] : 16'h0;
    always @(posedge clk) if (tx_pop) rd <= rd + 1;

    spi_m0_sequencer uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_bits(cfg_bits), .cfg_half(cfg_half),
        .tx_nonempty(tx_nonempty), .tx_word(tx_word), .tx_pop(tx_pop), .rx_valid(rx_valid),
        .rx_word(rx_word), .miso(miso), .sclk(sclk), .frame_n(frame_n), .mosi(mosi),
        .data_oe_n(data_oe_n), .clk_oe_n(clk_oe_n)
    );

    int checks = 0, errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor and slave model, sampled away from the active edge
    int cur_h = 1, cur_n = 8;
    int t_ffall, t_frise, t_first, t_last, t_oefall, t_oerise, t_rxv;
    int nrise, rises_last, nframes, nfalls, npop, nrx, ngap_oe, ngaps, gap_bad;
    bit have_rise;
    logic [15:0] cap, cap_last, sl_sh;
    logic [15:0] rxw [16];
    logic mosi_h;
    logic pf = 1'b1, ps = 1'b0, poe = 1'b1;
    assign miso = sl_sh[15];

    task automatic clear_mon();
        nrise = 0; rises_last = 0; nframes = 0; nfalls = 0; npop = 0; nrx = 0;
        ngap_oe = 0; ngaps = 0; gap_bad = 0; have_rise = 1'b0; cap = 0; mosi_h = 1'bx;
    endtask

    initial begin sl_sh = 16'h0; clear_mon(); end

    always @(negedge clk) begin
        if (rst_n) begin
            if (!frame_n && pf) begin
                t_ffall = cyc; cap = 0; nrise = 0; nfalls++;
                sl_sh = (sidx < 16) ? (sl_q[sidx] << (16 - cur_n)) : 16'h0;
                sidx++;
                if (have_rise) begin
                    ngaps++;
                    if (cyc - t_frise != 2 * cur_h) gap_bad++;
                end
            end
            if (frame_n && !pf) begin
                t_frise = cyc; have_rise = 1'b1; rises_last = nrise; cap_last = cap; nframes++;
            end
            if (!data_oe_n && poe) t_oefall = cyc;
            if (data_oe_n && !poe) t_oerise = cyc;
            if (sclk && !ps) begin
                if (nrise == 0) t_first = cyc;
                t_last = cyc; nrise++; cap = {cap[14:0], mosi};
            end
            if (!sclk && ps) sl_sh = sl_sh << 1;
            if (!frame_n && (cyc - t_ffall == cur_h)) mosi_h = mosi;
            if (tx_pop) npop++;
            if (rx_valid) begin
                t_rxv = cyc;
                if (nrx < 16) rxw[nrx] = rx_word;
                nrx++;
            end
            if (frame_n && !data_oe_n) ngap_oe++;
        end
        pf = frame_n; ps = sclk; poe = data_oe_n;
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_frames(int target);
        int guard = 0;
        while (nframes < target && guard < 20000) begin
            @(posedge clk); guard++;
        end
        if (guard >= 20000) begin
            errors++;
            $display("FAIL wait actual=%0d expected=%0d", nframes, target);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic push(logic [15:0] w, logic [15:0] s);
        q[nq] = w; sl_q[nq] = s; nq++;
    endtask

    // Stimulus table: word length request, half period, tx word, slave word
    localparam int NV = 6;
    localparam int          VB [NV] = '{8, 16, 2, 20, 5, 11};
    localparam int          VH [NV] = '{2, 1, 0, 3, 4, 1};
    localparam logic [15:0] VT [NV] = '{16'h00A5, 16'hC3E1, 16'h00B9, 16'h8001, 16'h000B, 16'h0555};
    localparam logic [15:0] VS [NV] = '{16'h005A, 16'h1234, 16'hFFF6, 16'hBEEF, 16'h0015, 16'h07AB};

    bit done = 1'b0;

    initial begin
        repeat (4) @(negedge clk);
        // R1 R2: reset levels
        check("R1 rst sclk", sclk, 0);
        check("R1 rst frame_n", frame_n, 1);
        check("R1 rst mosi", mosi, 0);
        check("R1 rst data_oe_n", data_oe_n, 1);
        check("R1 rst strobes", tx_pop + rx_valid, 0);
        check("R2 rst clk_oe_n", clk_oe_n, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 idle frame_n", frame_n, 1);
        check("R2 clk_oe_n", clk_oe_n, 0);

        enable = 1'b1;
        for (int i = 0; i < NV; i++) begin
            int n, h, mask;
            n = (VB[i] < 4) ? 4 : (VB[i] > 16 ? 16 : VB[i]);
            h = (VH[i] == 0) ? 1 : VH[i];
            mask = (1 << n) - 1;
            cur_n = n; cur_h = h;
            cfg_bits = 5'(VB[i]); cfg_half = 8'(VH[i]);
            clear_mon();
            push(VT[i], VS[i]);
            wait_frames(1);
            check("R5 rise count", rises_last, n);
            check("R5 mosi word", int'(cap_last), int'(VT[i]) & mask);
            check("R6 rx word", int'(rxw[0]), int'(VS[i]) & mask);
            check("R4 mosi msb after H", int'(mosi_h), (int'(VT[i]) >> (n - 1)) & 1);
            check("R4 first rise", t_first - t_ffall, 2 * h);
            check("R7 tail", t_frise - t_last, 2 * h);
            check("R7 valid with rise", t_rxv, t_frise);
            check("R9 oe rise", t_oerise, t_frise);
            check("R3 oe fall", t_oefall, t_ffall);
            check("R3 pop count", npop, 1);
        end

        // R11: disabled block ignores a waiting word
        enable = 1'b0; cur_n = 8; cur_h = 2; cfg_bits = 5'd8; cfg_half = 8'd2;
        clear_mon();
        push(16'h003C, 16'h00C3);
        repeat (100) @(negedge clk);
        check("R11 no frame", nfalls, 0);
        check("R11 no pop", npop, 0);
        check("R11 frame_n high", frame_n, 1);
        enable = 1'b1;
        wait_frames(1);
        check("R11 frame after enable", int'(rxw[0]), 16'h00C3);

        // R8: three words back to back
        cur_n = 6; cur_h = 3; cfg_bits = 5'd6; cfg_half = 8'd3;
        clear_mon();
        enable = 1'b0;
        push(16'h0021, 16'h0012); push(16'h003F, 16'h0001); push(16'h0010, 16'h002A);
        @(negedge clk);
        enable = 1'b1;
        wait_frames(3);
        check("R8 gaps", ngaps, 2);
        check("R8 gap length", gap_bad, 0);
        check("R8 oe low in gaps", ngap_oe, 2 * 2 * 3);
        check("R3 pops", npop, 3);
        check("R8 rx 0", int'(rxw[0]), 16'h0012);
        check("R8 rx 1", int'(rxw[1]), 16'h0001);
        check("R8 rx 2", int'(rxw[2]), 16'h002A);
        check("R9 oe rise at end", t_oerise, t_frise);

        // R10: configuration changed inside a frame
        cur_n = 8; cur_h = 2; cfg_bits = 5'd8; cfg_half = 8'd2;
        clear_mon();
        push(16'h0081, 16'h0066);
        while (nfalls == 0) @(negedge clk);
        cfg_bits = 5'd12; cfg_half = 8'd5;
        wait_frames(1);
        check("R10 rise count", rises_last, 8);
        check("R10 first rise", t_first - t_ffall, 4);
        check("R10 tail", t_frise - t_last, 4);
        check("R10 rx", int'(rxw[0]), 16'h0066);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule